// File: doc/BRIEF.md
# Configurable Edge-Sense Input Latch

This block monitors a group of asynchronous digital input lines and records, per line, whether a selected kind of transition has happened. A configuration word holds two enable bits for every line, one for the upward transition and one for the downward transition, so each line can be made sensitive to rising edges, falling edges, both or neither. A qualifying transition sets a sticky bit for that line. The bit stays set until software reads it.

The inputs pass through a multi-flop synchronizer before any edge is judged. A status read returns the sticky bits and the synchronized line levels together in one word. The same read clears exactly the sticky bits it returned. An edge seen in the same cycle as the read is kept, so it is not lost. An event output is high while notification is enabled and at least one sticky bit is set. A host interrupt controller can use it as a level request.

Top module: `sense_edge_latch`

## Requirements
- R1: While reset is asserted, and directly after it, the sticky bits are zero, `stat_word` is zero and `event_o` is low.
- R2: When configuration bit 2i is 1 and synchronized line i goes from 0 to 1, sticky bit i (status bit 8+i) becomes 1.
- R3: When configuration bit 2i+1 is 1 and synchronized line i goes from 1 to 0, sticky bit i becomes 1.
- R4: A line with both of its configuration bits set records both rising and falling transitions.
- R5: A transition whose polarity is not enabled for its line leaves that line's sticky bit unchanged.
- R6: A sticky bit that is set stays set after the line returns to its former level, until a status read.
- R7: Status bits 7:0 show the input levels two clock edges after they are applied to `sense_in`.
- R8: A cycle with `stat_rd` high clears, at the next edge, every sticky bit that was set during that cycle.
- R9: An enabled edge detected in the same cycle as `stat_rd` leaves its sticky bit set after the read.
- R10: `event_o` is high exactly when `evt_en` is high and at least one sticky bit is set.
- R11: Reset clears the configuration word. A word written with `cfg_wr` governs detection from the following edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Loads `cfg_data` into the configuration register |
| cfg_data | input | 16 | Edge enables: bit 2i rising, bit 2i+1 falling, for line i |
| evt_en | input | 1 | Event notification enable |
| sense_in | input | 8 | Asynchronous sense lines |
| stat_rd | input | 1 | Status read strobe, clears the returned sticky bits |
| stat_word | output | 16 | Sticky bits in 15:8, synchronized levels in 7:0 |
| event_o | output | 1 | Event level |

## Verification
Two functions can fall in the same cycle: the clear caused by a status read and the setting of a sticky bit by a fresh edge. To provoke this, the bench first leaves one line's bit set. It then changes a second line so that the second line's edge reaches the detector in exactly the cycle the read strobe is high. The status after that edge must show the old bit cleared and the new bit set. The bench also pairs a read with a configuration write in one cycle. It then checks that a line enabled only by the new word is recorded.

// File: rtl/sel_pkg.sv
package sel_pkg;

   // Per-line sensitivity, encoded as {falling_enable, rising_enable}
   typedef enum logic [1:0] {
      EDGE_OFF  = 2'b00,
      EDGE_RISE = 2'b01,
      EDGE_FALL = 2'b10,
      EDGE_ANY  = 2'b11
   } edge_mode_t;

   localparam int unsigned MAX_LINES = 32;

endpackage

// File: rtl/sel_sync.sv
module sel_sync #(
   parameter int WIDTH  = 8,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("sel_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [WIDTH-1:0] chain [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[s] <= '0;
               else        chain[s] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[s] <= '0;
               else        chain[s] <= chain[s-1];
            end
         end
      end
   endgenerate

   assign q = chain[STAGES-1];

endmodule

// File: rtl/sel_detect.sv
module sel_detect
   import sel_pkg::*;
#(
   parameter int LINES = 8,
   localparam int CFGW = 2 * LINES
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LINES-1:0] lvl,
   input  logic [CFGW-1:0]  cfg,
   output logic [LINES-1:0] hit
);

   logic [LINES-1:0] prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= lvl;
   end

   generate
      for (genvar g = 0; g < LINES; g++) begin : g_line
         edge_mode_t mode;
         logic       rise, fall;

         assign mode = edge_mode_t'(cfg[2*g+1 -: 2]);
         assign rise = lvl[g] & ~prev_q[g];
         assign fall = ~lvl[g] & prev_q[g];

         always_comb begin
            unique case (mode)
               EDGE_RISE: hit[g] = rise;
               EDGE_FALL: hit[g] = fall;
               EDGE_ANY:  hit[g] = rise | fall;
               default:   hit[g] = 1'b0;
            endcase
         end

         // R5
         line_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (mode == EDGE_OFF) |-> !hit[g]);
      end
   endgenerate

   // R5
   quiet_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lvl == prev_q) |-> (hit == '0));

endmodule

// File: rtl/sel_latch.sv
module sel_latch #(
   parameter int LINES = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LINES-1:0] hit,
   input  logic             rd,
   output logic [LINES-1:0] sticky_q
);

   logic [LINES-1:0] keep;

   assign keep = rd ? '0 : sticky_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sticky_q <= '0;
      else        sticky_q <= keep | hit;
   end

   // R6
   sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd |=> ((sticky_q & $past(sticky_q)) == $past(sticky_q)));

   // R8
   read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd |=> ((sticky_q & $past(sticky_q) & ~$past(hit)) == '0));

   // R9
   edge_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hit != '0) |=> ((sticky_q & $past(hit)) == $past(hit)));

endmodule

// File: rtl/sense_edge_latch.sv
module sense_edge_latch
   import sel_pkg::*;
#(
   parameter int LINES       = 8,
   parameter int SYNC_STAGES = 2,
   localparam int CFGW       = 2 * LINES,
   localparam int STATW      = 2 * LINES
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_wr,
   input  logic [CFGW-1:0]  cfg_data,
   input  logic             evt_en,
   input  logic [LINES-1:0] sense_in,
   input  logic             stat_rd,
   output logic [STATW-1:0] stat_word,
   output logic             event_o
);

   generate
      if (LINES < 1 || LINES > MAX_LINES) begin : g_bad_lines
         $error("sense_edge_latch: LINES out of range");
      end
   endgenerate

   logic [CFGW-1:0]  cfg_q;
   logic [LINES-1:0] lvl;
   logic [LINES-1:0] hit;
   logic [LINES-1:0] sticky;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cfg_q <= '0;
      else if (cfg_wr) cfg_q <= cfg_data;
   end

   sel_sync #(.WIDTH(LINES), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (sense_in),
      .q     (lvl)
   );

   sel_detect #(.LINES(LINES)) u_detect (
      .clk   (clk),
      .rst_n (rst_n),
      .lvl   (lvl),
      .cfg   (cfg_q),
      .hit   (hit)
   );

   sel_latch #(.LINES(LINES)) u_latch (
      .clk      (clk),
      .rst_n    (rst_n),
      .hit      (hit),
      .rd       (stat_rd),
      .sticky_q (sticky)
   );

   assign stat_word = {sticky, lvl};
   assign event_o   = evt_en & (|sticky);

   // R10
   event_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !evt_en |-> !event_o);

   // R10
   event_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      event_o |-> (stat_word[STATW-1:LINES] != '0));

endmodule

// File: tb/sense_edge_latch_tb.sv
module sense_edge_latch_tb;

   localparam int LINES = 8;
   localparam int STATW = 2 * LINES;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             cfg_wr = 1'b0;
   logic [STATW-1:0] cfg_data = '0;
   logic             evt_en = 1'b0;
   logic [LINES-1:0] sense_in = '0;
   logic             stat_rd = 1'b0;
   logic [STATW-1:0] stat_word;
   logic             event_o;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   typedef struct {
      logic [STATW-1:0] stat;
      logic             evt;
      string            tag;
   } item_t;

   item_t sb[$];

   always #4 clk = ~clk;

   sense_edge_latch #(.LINES(LINES)) u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_wr    (cfg_wr),
      .cfg_data  (cfg_data),
      .evt_en    (evt_en),
      .sense_in  (sense_in),
      .stat_rd   (stat_rd),
      .stat_word (stat_word),
      .event_o   (event_o)
   );

   // monitor: compares 2 ns after each rising edge
   initial begin
      forever begin
         @(posedge clk);
         #2;
         if (sb.size() > 0) begin
            item_t it;
            it = sb.pop_front();
            total++;
            if (stat_word !== it.stat) begin
               bad++;
               $display("FAIL %s stat_word actual=%h expected=%h", it.tag, stat_word, it.stat);
            end
            total++;
            if (event_o !== it.evt) begin
               bad++;
               $display("FAIL %s event_o actual=%b expected=%b", it.tag, event_o, it.evt);
            end
         end
      end
   end

   // one edge; optionally expect the state after it
   task automatic tick(input bit chk, input logic [STATW-1:0] st, input logic ev, input string tag);
      if (chk) sb.push_back('{stat: st, evt: ev, tag: tag});
      @(negedge clk);
   endtask

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) tick(1'b0, '0, 1'b0, "");
   endtask

   initial begin
      @(negedge clk);
      tick(1'b1, 16'h0000, 1'b0, "R1 in reset");
      rst_n = 1'b1;
      tick(1'b1, 16'h0000, 1'b0, "R1 after release");

      // no configuration yet: levels show, nothing latched
      sense_in = 8'hFF;
      tick(1'b1, 16'h0000, 1'b0, "R7 first stage");
      tick(1'b1, 16'h00FF, 1'b0, "R7 levels");
      tick(1'b1, 16'h00FF, 1'b0, "R11 cleared config");

      // line0 rise, line1 fall, line2 both
      cfg_wr = 1'b1; cfg_data = 16'h0039; evt_en = 1'b1;
      tick(1'b1, 16'h00FF, 1'b0, "R11 write");
      cfg_wr = 1'b0;
      sense_in = 8'h00;
      tick(1'b1, 16'h00FF, 1'b0, "R7 hold");
      tick(1'b1, 16'h0000, 1'b0, "R10 no event yet");
      tick(1'b1, 16'h0600, 1'b1, "R3 R4 R5 R10 falling");

      sense_in = 8'h01;
      tick(1'b1, 16'h0600, 1'b1, "R6");
      tick(1'b1, 16'h0601, 1'b1, "R7");
      tick(1'b1, 16'h0701, 1'b1, "R2 rising");
      sense_in = 8'h00;
      idle(2);
      tick(1'b1, 16'h0700, 1'b1, "R6 R5 sticky");

      stat_rd = 1'b1;
      tick(1'b1, 16'h0000, 1'b0, "R8 read clear");
      stat_rd = 1'b0;

      // leave line1 set, then read while line2 edge arrives
      sense_in = 8'h02;
      idle(3);
      sense_in = 8'h00;
      idle(2);
      tick(1'b1, 16'h0200, 1'b1, "R3 line1");
      sense_in = 8'h04;
      tick(1'b1, 16'h0200, 1'b1, "R6");
      tick(1'b1, 16'h0204, 1'b1, "R7");
      stat_rd = 1'b1;
      tick(1'b1, 16'h0404, 1'b1, "R9 R8 same cycle");
      stat_rd = 1'b0;

      evt_en = 1'b0;
      tick(1'b1, 16'h0404, 1'b0, "R10 disabled");
      evt_en = 1'b1;
      tick(1'b1, 16'h0404, 1'b1, "R10 enabled");

      // read and rewrite configuration in one cycle
      stat_rd = 1'b1; cfg_wr = 1'b1; cfg_data = 16'hFFFF;
      tick(1'b1, 16'h0004, 1'b0, "R8 R11");
      stat_rd = 1'b0; cfg_wr = 1'b0;
      sense_in = 8'hF0;
      tick(1'b1, 16'h0004, 1'b0, "R7");
      tick(1'b1, 16'h00F0, 1'b0, "R7");
      tick(1'b1, 16'hF4F0, 1'b1, "R11 new config R4");

      // second reset
      rst_n = 1'b0;
      tick(1'b1, 16'h0000, 1'b0, "R1 mid-run reset");
      rst_n = 1'b1;
      tick(1'b1, 16'h0000, 1'b0, "R1 release");
      tick(1'b1, 16'h00F0, 1'b0, "R7 after reset");
      tick(1'b1, 16'h00F0, 1'b0, "R11 config cleared by reset");

      idle(3);
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            #(8 * 20000);
            total++;
            bad++;
            $display("FAIL watchdog expired");
         end
      join_any
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule